// File: doc/BRIEF.md
# MOV/ADD Instruction Field Decoder

This block takes the bytes of a variable-length instruction one at a time and breaks them into their fields. It covers the register, memory, immediate, accumulator and segment-register forms of the move and add instructions of a 16-bit two-operand instruction set. A byte is taken on every clock where `byte_valid` is high. Cycles with `byte_valid` low are ignored. The first byte is treated as the opcode. From it, and from the mode byte when one follows, the decoder works out how many address-offset bytes and immediate bytes come after. It assembles those bytes, low byte first, into 16-bit values.

When the last byte of an instruction has been taken, the decoder pulses `done` for one cycle. The decoded record is then present on the output ports. It stays there until the next valid byte arrives, which the decoder treats as a new opcode. If the decoder meets an opcode it does not support, or a mode byte whose middle field is illegal for the opcode, it pulses `err` and drops the partial instruction.

The block does not execute the instruction and does not compute addresses.

Top module: `insn_field_decoder`

## Requirements
- R1: After reset, `done` and `err` are low and `cls` reads 15 (no instruction). The first valid byte after reset is taken as an opcode.
- R2: The opcode selects `cls` as follows:
  - 100010dw gives 0 (move, register with register or memory).
  - 1100011w gives 1 (move immediate to register or memory).
  - 1011wrrr gives 2 (move immediate to register).
  - 1010000w gives 3 (load accumulator from direct address).
  - 1010001w gives 4 (store accumulator to direct address).
  - 10001110 gives 5 (move to segment register).
  - 10001100 gives 6 (move from segment register).
  - 000000dw gives 7 (add, register with register or memory).
  - 100000sw gives 8 (add immediate to register or memory).
  - 0000010w gives 9 (add immediate to accumulator).
- R3: Opcode flag outputs:
  - `d_bit` is opcode bit 1 for classes 0, 5, 6 and 7, and 0 for all others.
  - `s_bit` is opcode bit 1 for class 8, and 0 for all others.
  - `w_bit` is opcode bit 3 for class 2, 1 for classes 5 and 6, and opcode bit 0 for all others.
- R4: Mode byte fields:
  - Classes 0, 1, 5, 6, 7 and 8 take a mode byte. For these, `has_modrm` is 1, and `mod_f`, `reg_f` and `rm_f` are its bits 7:6, 5:3 and 2:0. For classes 5 and 6, the segment code (ES=0, CS=1, SS=2, DS=3) is `reg_f[1:0]`.
  - Classes 2, 3, 4 and 9 have no mode byte. For these, `has_modrm`, `mod_f` and `rm_f` are 0. `reg_f` is opcode bits 2:0 for class 2 and 0 otherwise.
- R5: Offset bytes are counted as follows:
  - The offset has 1 byte for mod=01 and 2 bytes for mod=10.
  - For mod=00 the offset has 2 bytes when rm=110, and none otherwise. mod=11 has no offset.
  - Classes 3 and 4 carry a 2-byte address in `disp`.
  - A 1-byte offset is sign-extended into `disp`. Multi-byte values arrive low byte first. With no offset, `disp` is 0.
- R6: Immediate bytes are counted as follows:
  - Classes 1, 2 and 9 carry 2 immediate bytes when w=1 and 1 byte when w=0.
  - Class 8 carries 2 bytes only when s=0 and w=1, and 1 byte otherwise.
  - For class 8 with s=1 and w=1, the byte is sign-extended into `imm`. Every other 1-byte immediate has a zero high byte.
  - With no immediate, `imm` is 0.
- R7: `ins_len` equals the number of bytes in the instruction. `done` rises in the cycle after the clock edge that took the last byte, and lasts one cycle.
- R8: An opcode byte that matches no form in R2 causes a one-cycle `err` pulse in the following cycle. The next valid byte is then decoded as an opcode.
- R9: A mode byte is illegal when either of these holds. The decoder then pulses `err` one cycle later and waits for a new opcode.
  - The class is 1 or 8 and `reg` is not 000.
  - The class is 5 or 6 and bit 5 of the mode byte is set.
- R10: Cycles with `byte_valid` low do not change the decode. Any number of them may fall between the bytes of an instruction. After `done`, the record holds until the next valid byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | `byte_in` holds an instruction byte this cycle |
| byte_in | input | 8 | Instruction byte |
| done | output | 1 | One-cycle pulse: record complete |
| err | output | 1 | One-cycle pulse: illegal opcode or mode byte |
| cls | output | 4 | Instruction class (R2) |
| d_bit | output | 1 | Direction flag |
| w_bit | output | 1 | Word-size flag |
| s_bit | output | 1 | Sign-extend flag |
| has_modrm | output | 1 | A mode byte was present |
| mod_f | output | 2 | Mode field |
| reg_f | output | 3 | Register or segment field |
| rm_f | output | 3 | Register/memory field |
| disp | output | 16 | Offset or direct address |
| imm | output | 16 | Immediate data |
| ins_len | output | 3 | Total instruction length in bytes |

## Verification
A miscount of offset or immediate bytes shows at the ports at once. `done` appears one byte early or late, and the next instruction's opcode is read as data, so a burst of wrong records or `err` pulses follows within a few bytes. A corrupted phase or position state shows as the wrong byte lane in `disp` or `imm`, or as a `done` after a gap cycle. The scoreboard catches both on the same `done` pulse. Hold and gap tests show any state that moves while `byte_valid` is low.

// File: rtl/insn_field_decoder.sv
module insn_field_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_valid,
  input  logic [7:0]  byte_in,
  output logic        done,
  output logic        err,
  output logic [3:0]  cls,
  output logic        d_bit,
  output logic        w_bit,
  output logic        s_bit,
  output logic        has_modrm,
  output logic [1:0]  mod_f,
  output logic [2:0]  reg_f,
  output logic [2:0]  rm_f,
  output logic [15:0] disp,
  output logic [15:0] imm,
  output logic [2:0]  ins_len
);
  localparam logic [3:0] C_MOV_RM   = 4'd0;
  localparam logic [3:0] C_MOV_IRM  = 4'd1;
  localparam logic [3:0] C_MOV_IREG = 4'd2;
  localparam logic [3:0] C_MOV_LD   = 4'd3;
  localparam logic [3:0] C_MOV_ST   = 4'd4;
  localparam logic [3:0] C_SEG_TO   = 4'd5;
  localparam logic [3:0] C_SEG_FROM = 4'd6;
  localparam logic [3:0] C_ADD_RM   = 4'd7;
  localparam logic [3:0] C_ADD_IRM  = 4'd8;
  localparam logic [3:0] C_ADD_ACC  = 4'd9;
  localparam logic [3:0] C_NONE     = 4'd15;

  typedef enum logic [1:0] {P_OP, P_MODRM, P_DISP, P_DATA} phase_t;

  phase_t     phase;
  logic [1:0] disp_n, data_n;
  logic       hi, dsx, isx;

  logic [3:0] oc;
  logic       o_modrm, o_w, o_d, o_s, o_sx;
  logic [1:0] o_disp, o_data;
  logic [2:0] o_len;

  always_comb begin
    casez (byte_in)
      8'b100010??: oc = C_MOV_RM;
      8'b1100011?: oc = C_MOV_IRM;
      8'b1011????: oc = C_MOV_IREG;
      8'b1010000?: oc = C_MOV_LD;
      8'b1010001?: oc = C_MOV_ST;
      8'b10001110: oc = C_SEG_TO;
      8'b10001100: oc = C_SEG_FROM;
      8'b000000??: oc = C_ADD_RM;
      8'b100000??: oc = C_ADD_IRM;
      8'b0000010?: oc = C_ADD_ACC;
      default:     oc = C_NONE;
    endcase
  end

  wire o_seg = (oc == C_SEG_TO) || (oc == C_SEG_FROM);
  assign o_modrm = (oc == C_MOV_RM) || (oc == C_MOV_IRM) || o_seg ||
                   (oc == C_ADD_RM) || (oc == C_ADD_IRM);
  assign o_w = (oc == C_MOV_IREG) ? byte_in[3] : (o_seg ? 1'b1 : byte_in[0]);
  assign o_d = ((oc == C_MOV_RM) || o_seg || (oc == C_ADD_RM)) ? byte_in[1] : 1'b0;
  assign o_s = (oc == C_ADD_IRM) ? byte_in[1] : 1'b0;
  assign o_sx = (oc == C_ADD_IRM) && byte_in[1] && byte_in[0];
  assign o_disp = ((oc == C_MOV_LD) || (oc == C_MOV_ST)) ? 2'd2 : 2'd0;

  always_comb begin
    case (oc)
      C_MOV_IRM, C_MOV_IREG, C_ADD_ACC: o_data = o_w ? 2'd2 : 2'd1;
      C_ADD_IRM: o_data = (byte_in[0] && !byte_in[1]) ? 2'd2 : 2'd1;
      default:   o_data = 2'd0;
    endcase
  end

  assign o_len = 3'd1 + {2'b00, o_modrm} + {1'b0, o_disp} + {1'b0, o_data};

  wire [1:0] m_mod = byte_in[7:6];
  wire [2:0] m_reg = byte_in[5:3];
  wire [2:0] m_rm  = byte_in[2:0];
  logic [1:0] m_disp;
  always_comb begin
    case (m_mod)
      2'b01:   m_disp = 2'd1;
      2'b10:   m_disp = 2'd2;
      2'b00:   m_disp = (m_rm == 3'b110) ? 2'd2 : 2'd0;
      default: m_disp = 2'd0;
    endcase
  end
  wire m_bad = (((cls == C_MOV_IRM) || (cls == C_ADD_IRM)) && (m_reg != 3'b000)) ||
               (((cls == C_SEG_TO) || (cls == C_SEG_FROM)) && m_reg[2]);

  wire disp_last = hi || (disp_n == 2'd1);
  wire data_last = hi || (data_n == 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_OP;
      done <= 1'b0;
      err <= 1'b0;
      cls <= C_NONE;
      d_bit <= 1'b0;
      w_bit <= 1'b0;
      s_bit <= 1'b0;
      has_modrm <= 1'b0;
      mod_f <= '0;
      reg_f <= '0;
      rm_f <= '0;
      disp <= '0;
      imm <= '0;
      ins_len <= '0;
      disp_n <= '0;
      data_n <= '0;
      hi <= 1'b0;
      dsx <= 1'b0;
      isx <= 1'b0;
    end else begin
      done <= 1'b0;
      err <= 1'b0;
      if (byte_valid) begin
        case (phase)
          P_OP: begin
            if (oc == C_NONE) begin
              err <= 1'b1;
            end else begin
              cls <= oc;
              d_bit <= o_d;
              w_bit <= o_w;
              s_bit <= o_s;
              has_modrm <= o_modrm;
              mod_f <= '0;
              reg_f <= (oc == C_MOV_IREG) ? byte_in[2:0] : 3'b000;
              rm_f <= '0;
              disp <= '0;
              imm <= '0;
              ins_len <= o_len;
              disp_n <= o_disp;
              data_n <= o_data;
              isx <= o_sx;
              dsx <= 1'b0;
              hi <= 1'b0;
              if (o_modrm) phase <= P_MODRM;
              else if (o_disp != 2'd0) phase <= P_DISP;
              else phase <= P_DATA;
            end
          end
          P_MODRM: begin
            if (m_bad) begin
              err <= 1'b1;
              phase <= P_OP;
            end else begin
              mod_f <= m_mod;
              reg_f <= m_reg;
              rm_f <= m_rm;
              ins_len <= ins_len + {1'b0, m_disp};
              disp_n <= m_disp;
              dsx <= (m_mod == 2'b01);
              if (m_disp != 2'd0) phase <= P_DISP;
              else if (data_n != 2'd0) phase <= P_DATA;
              else begin
                done <= 1'b1;
                phase <= P_OP;
              end
            end
          end
          P_DISP: begin
            if (!hi) disp <= {dsx ? {8{byte_in[7]}} : 8'h00, byte_in};
            else disp[15:8] <= byte_in;
            if (disp_last) begin
              hi <= 1'b0;
              if (data_n != 2'd0) phase <= P_DATA;
              else begin
                done <= 1'b1;
                phase <= P_OP;
              end
            end else begin
              hi <= 1'b1;
            end
          end
          default: begin
            if (!hi) imm <= {isx ? {8{byte_in[7]}} : 8'h00, byte_in};
            else imm[15:8] <= byte_in;
            if (data_last) begin
              hi <= 1'b0;
              done <= 1'b1;
              phase <= P_OP;
            end else begin
              hi <= 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

module insn_field_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        byte_valid,
  input logic        done,
  input logic        err,
  input logic [3:0]  cls,
  input logic        s_bit,
  input logic        w_bit,
  input logic        has_modrm,
  input logic [1:0]  mod_f,
  input logic [2:0]  reg_f,
  input logic [2:0]  rm_f,
  input logic [15:0] disp,
  input logic [15:0] imm,
  input logic [2:0]  ins_len
);
  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  assert_err_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(byte_valid));
  assert_done_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(byte_valid));
  assert_single_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_len_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ins_len >= 3'd2) && (ins_len <= 3'd6));
  assert_nomodrm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !has_modrm) |-> (mod_f == 2'b00) && (rm_f == 3'b000));
  assert_imm_sx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cls == 4'd8 && s_bit && w_bit) |-> (imm[15:8] == {8{imm[7]}}));
  assert_immrm_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (cls == 4'd1 || cls == 4'd8)) |-> (reg_f == 3'b000));
  assert_seg_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (cls == 4'd5 || cls == 4'd6)) |-> !reg_f[2]);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(byte_valid) |-> ($stable(disp) && $stable(imm) && $stable(ins_len) && $stable(cls)));
endmodule

bind insn_field_decoder insn_field_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .done(done), .err(err),
  .cls(cls), .s_bit(s_bit), .w_bit(w_bit), .has_modrm(has_modrm),
  .mod_f(mod_f), .reg_f(reg_f), .rm_f(rm_f), .disp(disp), .imm(imm),
  .ins_len(ins_len)
);

// File: tb/test_insn_field_decoder.sv
`timescale 1ns/1ps
module test_insn_field_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_valid = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic done, err, d_bit, w_bit, s_bit, has_modrm;
  logic [3:0] cls;
  logic [1:0] mod_f;
  logic [2:0] reg_f, rm_f, ins_len;
  logic [15:0] disp, imm;

  insn_field_decoder i_insn_field_decoder (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
    .done(done), .err(err), .cls(cls), .d_bit(d_bit), .w_bit(w_bit),
    .s_bit(s_bit), .has_modrm(has_modrm), .mod_f(mod_f), .reg_f(reg_f),
    .rm_f(rm_f), .disp(disp), .imm(imm), .ins_len(ins_len)
  );

  always #2 clk = ~clk;

  typedef struct packed {
    logic        is_err;
    logic [3:0]  c;
    logic        d, w, s, hm;
    logic [1:0]  mo;
    logic [2:0]  rg, rm;
    logic [15:0] dp, im;
    logic [2:0]  ln;
  } exp_t;

  exp_t  sb[$];
  string tq[$];
  exp_t  last_e;
  int total = 0;
  int bad = 0;

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic cmp_rec(input exp_t e, input string t);
    chk({t, " cls"}, {12'd0, cls}, {12'd0, e.c});
    chk({t, " d"}, {15'd0, d_bit}, {15'd0, e.d});
    chk({t, " w"}, {15'd0, w_bit}, {15'd0, e.w});
    chk({t, " s"}, {15'd0, s_bit}, {15'd0, e.s});
    chk({t, " modrm"}, {15'd0, has_modrm}, {15'd0, e.hm});
    chk({t, " mod"}, {14'd0, mod_f}, {14'd0, e.mo});
    chk({t, " reg"}, {13'd0, reg_f}, {13'd0, e.rg});
    chk({t, " rm"}, {13'd0, rm_f}, {13'd0, e.rm});
    chk({t, " disp"}, disp, e.dp);
    chk({t, " imm"}, imm, e.im);
    chk({t, " len"}, {13'd0, ins_len}, {13'd0, e.ln});
  endtask

  function automatic exp_t mk(input logic [3:0] c, input logic d, input logic w,
                              input logic s, input logic hm, input logic [1:0] mo,
                              input logic [2:0] rg, input logic [2:0] rm,
                              input logic [15:0] dp, input logic [15:0] im,
                              input logic [2:0] ln);
    exp_t e;
    e.is_err = 1'b0; e.c = c; e.d = d; e.w = w; e.s = s; e.hm = hm;
    e.mo = mo; e.rg = rg; e.rm = rm; e.dp = dp; e.im = im; e.ln = ln;
    return e;
  endfunction

  function automatic exp_t mkerr();
    exp_t e;
    e = '0;
    e.is_err = 1'b1;
    return e;
  endfunction

  // driver: bytes packed with the first byte in bits 7:0
  task automatic send(input int n, input logic [47:0] b, input exp_t e,
                      input string t, input int gap);
    sb.push_back(e);
    tq.push_back(t);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_valid = 1'b1;
      byte_in = b[8*i +: 8];
      if (gap > 0) begin
        @(negedge clk);
        byte_valid = 1'b0;
        byte_in = 8'hA5;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    byte_valid = 1'b0;
    byte_in = 8'h00;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && (done || err)) begin
      if (sb.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R7 unexpected pulse actual=%b%b expected=00", done, err);
      end else begin
        exp_t e;
        string t;
        e = sb.pop_front();
        t = tq.pop_front();
        chk({t, " kind"}, {14'd0, done, err}, e.is_err ? 16'd1 : 16'd2);
        if (!e.is_err && done) begin
          cmp_rec(e, t);
          last_e = e;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done in reset", {15'd0, done}, 16'd0);
    chk("R1 err in reset", {15'd0, err}, 16'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 done after reset", {15'd0, done}, 16'd0);
    chk("R1 cls after reset", {12'd0, cls}, 16'd15);

    send(2, 48'h1C8A, mk(0,1,0,0,1,0,3,4,16'h0,16'h0,2), "R1 R2 R3 R4", 0);
    send(2, 48'h0F89, mk(0,0,1,0,1,0,1,7,16'h0,16'h0,2), "R2 R3 R4", 0);
    send(4, 48'h1234978B, mk(0,1,1,0,1,2,2,7,16'h1234,16'h0,4), "R5 R7", 0);
    send(2, 48'hC189, mk(0,0,1,0,1,3,0,1,16'h0,16'h0,2), "R4 reg-reg", 0);
    send(3, 48'hFE00BA, mk(2,0,1,0,0,0,2,0,16'h0,16'hFE00,3), "R2 R4 R6 short", 0);
    send(4, 48'hFE00C2C7, mk(1,0,1,0,1,3,0,2,16'h0,16'hFE00,4), "R2 R6", 0);
    send(6, 48'h6789FFFE84C7, mk(1,0,1,0,1,2,0,4,16'hFFFE,16'h6789,6), "R5 R6 R7 max", 0);
    send(5, 48'h67664806C6, mk(1,0,0,0,1,0,0,6,16'h6648,16'h0067,5), "R5 direct", 0);
    send(3, 48'h6648A0, mk(3,0,0,0,0,0,0,0,16'h6648,16'h0,3), "R2 R5 load", 0);
    send(3, 48'h1234A3, mk(4,0,1,0,0,0,0,0,16'h1234,16'h0,3), "R2 R5 store", 0);
    send(2, 48'hD88E, mk(5,1,1,0,1,3,3,0,16'h0,16'h0,2), "R2 R3 R4 seg", 0);
    send(3, 48'h804F8C, mk(6,0,1,0,1,1,1,7,16'hFF80,16'h0,3), "R4 R5 sx8", 0);
    send(2, 48'h1C03, mk(7,1,1,0,1,0,3,4,16'h0,16'h0,2), "R2 add", 0);
    send(3, 48'h123405, mk(9,0,1,0,0,0,0,0,16'h0,16'h1234,3), "R2 R6 acc", 0);
    send(2, 48'h7F04, mk(9,0,0,0,0,0,0,0,16'h0,16'h007F,2), "R6 acc byte", 0);
    send(4, 48'h0036C381, mk(8,0,1,0,1,3,0,3,16'h0,16'h0036,4), "R3 R6 s0", 0);
    send(3, 48'h80C183, mk(8,0,1,1,1,3,0,1,16'h0,16'hFF80,3), "R3 R6 sx", 0);
    send(5, 48'hF020100680, mk(8,0,0,0,1,0,0,6,16'h2010,16'h00F0,5), "R6 w0 zext", 0);
    send(4, 48'h05F04583, mk(8,0,1,1,1,1,0,5,16'hFFF0,16'h0005,4), "R5 R6 mixed", 0);
    send(3, 48'h90C082, mk(8,0,0,1,1,3,0,0,16'h0,16'h0090,3), "R6 s1 w0", 0);
    send(3, 48'h05468B, mk(0,1,1,0,1,1,0,6,16'h0005,16'h0,3), "R5 bp disp8", 0);

    send(1, 48'h0F, mkerr(), "R8 bad opcode", 0);
    send(2, 48'h1C8A, mk(0,1,0,0,1,0,3,4,16'h0,16'h0,2), "R8 recovery", 0);
    send(1, 48'h8D, mkerr(), "R8 bad seg opcode", 0);
    send(2, 48'hC8C7, mkerr(), "R9 imm reg field", 0);
    send(2, 48'h7F04, mk(9,0,0,0,0,0,0,0,16'h0,16'h007F,2), "R9 recovery", 0);
    send(2, 48'hE08E, mkerr(), "R9 seg code", 0);
    send(2, 48'h0881, mkerr(), "R9 add imm reg", 0);

    send(4, 48'h1234978B, mk(0,1,1,0,1,2,2,7,16'h1234,16'h0,4), "R10 gaps", 3);
    repeat (5) @(negedge clk);
    cmp_rec(last_e, "R10 hold");

    repeat (4) @(negedge clk);
    chk("R7 all results seen", sb.size()[15:0], 16'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule